// File: doc/BRIEF.md
# IR Carrier Waveform Generator

This block turns a fast IR clock into the square-wave carrier used by an infrared transmitter. Software sets two separate counts: the number of IR clock cycles the carrier stays high and the number it stays low. The duty cycle can therefore be anything from a short pulse to a constant level. Every period starts with its high phase. On the last cycle of each full period the block raises a one-cycle tick. Downstream logic counts these ticks to time marks, spaces and repeat intervals.

A gate input decides whether the carrier reaches the pin. While the gate is low the pin sits at its idle level, but the carrier counter keeps running, so the carrier phase stays continuous from one mark to the next. A polarity control inverts the final pin level. The pin and the tick are both registered, so each follows the internal carrier state, the gate and the polarity control one clock edge later.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `irOut` and `carrierTick` are 0.
- R2: With a nonzero high count H and the gate open, each run of `irOut` = 1 (non-inverted) lasts exactly H clock cycles.
- R3: With a nonzero low count L, each run of `irOut` = 0 between high runs lasts exactly L clock cycles.
- R4: `carrierTick` is 1 for exactly one cycle per period of H+L cycles. When L is nonzero, that cycle is the last cycle of the low run.
- R5: A high count of 0 is a programming error. The carrier stays off: `irOut` stays at its idle level and no tick is produced.
- R6: A low count of 0 gives a constant high output while the gate is open, with one tick every H cycles.
- R7: While `enable` is 0 the counter is held, `irOut` is at its idle level and no tick occurs. After `enable` is sampled 1 on an edge, `irOut` starts a high phase on the following edge.
- R8: While `gate` is 0, `irOut` is at its idle level. Ticks continue at one per H+L cycles.
- R9: With `invert` = 1 the pin shows the logical inverse of the gated carrier, so the idle level is 1. A change on `gate` or `invert` appears on `irOut` after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IR clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the carrier; 0 holds the counter in reset |
| highCnt | input | 10 | Carrier high time in clock cycles, must be nonzero |
| lowCnt | input | 10 | Carrier low time in clock cycles, 0 allowed |
| gate | input | 1 | 1 passes the carrier to the pin, 0 forces idle level |
| invert | input | 1 | 1 inverts the pin |
| irOut | output | 1 | Registered IR output pin |
| carrierTick | output | 1 | One-cycle pulse on the last cycle of each carrier period |

## Verification
A wrong count value or phase state shows up within a single carrier period. The high or low run on `irOut` comes out longer or shorter than programmed, and the tick moves off the last low cycle. A counter that stops while the gate is closed, or does not clear on disable, shows as a missing or extra tick over a window several periods long. The off-period tick counts are set up to catch exactly that. Polarity and gating faults appear on the pin one edge after the control changes.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHigh;
    logic loadLow;
    logic countDown;
    logic clear;
    logic carrierOn;
    logic tick;
  } strobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic cntZero;
    logic highZero;
    logic lowZero;
  } cue_t;
endpackage

// File: rtl/ir_carrier_ctrl.sv
module ir_carrier_ctrl
  import ir_carrier_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  cue_t    cue,
  output strobe_t strb
);
  phase_e phase, phaseNext;
  logic run;

  assign run = enable && !cue.highZero;

  always_comb begin
    phaseNext = phase;
    strb = '0;
    case (phase)
      PH_IDLE: begin
        if (run) begin
          phaseNext = PH_HIGH;
          strb.loadHigh = 1'b1;
        end
      end
      PH_HIGH: begin
        strb.carrierOn = 1'b1;
        if (!run) begin
          phaseNext = PH_IDLE;
          strb.clear = 1'b1;
        end else if (cue.cntZero) begin
          if (cue.lowZero) begin
            strb.tick = 1'b1;
            strb.loadHigh = 1'b1;
          end else begin
            phaseNext = PH_LOW;
            strb.loadLow = 1'b1;
          end
        end else begin
          strb.countDown = 1'b1;
        end
      end
      PH_LOW: begin
        if (!run) begin
          phaseNext = PH_IDLE;
          strb.clear = 1'b1;
        end else if (cue.cntZero) begin
          phaseNext = PH_HIGH;
          strb.tick = 1'b1;
          strb.loadHigh = 1'b1;
        end else begin
          strb.countDown = 1'b1;
        end
      end
      default: begin
        phaseNext = PH_IDLE;
        strb.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // R7: disabled means back to idle on the next edge
  p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> phase == PH_IDLE);

  // R5: zero high count never leaves the carrier on
  p_zero_high_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    cue.highZero |=> !strb.carrierOn);

  // R4: every low-to-high transition is marked by a tick
  p_period_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && $past(phase) == PH_LOW) |-> $past(strb.tick));

  // R2: counter commands are mutually exclusive
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadHigh, strb.loadLow, strb.countDown, strb.clear}));
endmodule

// File: rtl/ir_carrier_dp.sv
module ir_carrier_dp
  import ir_carrier_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] highCnt,
  input  logic [CW-1:0] lowCnt,
  input  logic          gate,
  input  logic          invert,
  input  strobe_t       strb,
  output cue_t          cue,
  output logic          irOut,
  output logic          carrierTick
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  assign cue.cntZero  = (cnt == '0);
  assign cue.highZero = (highCnt == '0);
  assign cue.lowZero  = (lowCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) cnt <= '0;
    else if (strb.loadHigh)  cnt <= highCnt - ONE;
    else if (strb.loadLow)   cnt <= lowCnt - ONE;
    else if (strb.countDown) cnt <= cnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irOut       <= 1'b0;
      carrierTick <= 1'b0;
    end else begin
      irOut       <= invert ^ (gate & strb.carrierOn);
      carrierTick <= strb.tick;
    end
  end

  // R2: a load of the high phase starts at H-1
  p_load_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadHigh && !strb.clear) |=> cnt == $past(highCnt) - ONE);

  // R8: closed gate gives the idle level one edge later
  p_gate_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !gate |=> irOut == $past(invert));

  // R3: low phase loads only with a nonzero low count
  p_low_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |-> !cue.lowZero);
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [CW-1:0] highCnt,
  input  logic [CW-1:0] lowCnt,
  input  logic          gate,
  input  logic          invert,
  output logic          irOut,
  output logic          carrierTick
);
  strobe_t strb;
  cue_t    cue;

  ir_carrier_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .cue    (cue),
    .strb   (strb)
  );

  ir_carrier_dp #(.CW(CW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .highCnt     (highCnt),
    .lowCnt      (lowCnt),
    .gate        (gate),
    .invert      (invert),
    .strb        (strb),
    .cue         (cue),
    .irOut       (irOut),
    .carrierTick (carrierTick)
  );

  // R1: outputs quiet while in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!irOut && !carrierTick));
endmodule

// File: tb/tb_ir_carrier_gen.sv
module tb_ir_carrier_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [9:0] highCnt = '0;
  logic [9:0] lowCnt = '0;
  logic gate = 1'b0;
  logic invert = 1'b0;
  logic irOut, carrierTick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam int NV = 6;
  localparam int VHI [NV] = '{3, 1, 5, 2, 7, 1};
  localparam int VLO [NV] = '{2, 1, 1, 4, 3, 3};

  ir_carrier_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .highCnt(highCnt), .lowCnt(lowCnt),
    .gate(gate), .invert(invert), .irOut(irOut), .carrierTick(carrierTick)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  // wait (at negedges) until irOut equals lvl, bounded
  task automatic wait_level(input logic lvl);
    for (int i = 0; i < 3000 && irOut != lvl; i++) @(negedge clk);
  endtask

  // count ticks and cycles where irOut==lvl over n cycles
  task automatic window(input int n, input logic lvl, output int ticks, output int hits);
    ticks = 0; hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (carrierTick) ticks++;
      if (irOut == lvl) hits++;
    end
  endtask

  task automatic restart(input int h, input int l);
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    highCnt = 10'(h);
    lowCnt = 10'(l);
    enable = 1'b1;
  endtask

  initial begin
    int hiLen, loLen, tk, lastTick, hits;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 irOut in reset", int'(irOut), 0);
    check("R1 tick in reset", int'(carrierTick), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irOut after reset", int'(irOut), 0);
    check("R1 tick after reset", int'(carrierTick), 0);

    // table walk: R2, R3, R4
    gate = 1'b1;
    for (int v = 0; v < NV; v++) begin
      restart(VHI[v], VLO[v]);
      wait_level(1'b1);
      hiLen = 0; loLen = 0; tk = 0; lastTick = 0;
      for (int i = 0; i < 3000 && irOut; i++) begin
        if (carrierTick) tk++;
        hiLen++;
        @(negedge clk);
      end
      for (int i = 0; i < 3000 && !irOut; i++) begin
        if (carrierTick) tk++;
        lastTick = int'(carrierTick);
        loLen++;
        @(negedge clk);
      end
      check($sformatf("R2 high run h=%0d", VHI[v]), hiLen, VHI[v]);
      check($sformatf("R3 low run l=%0d", VLO[v]), loLen, VLO[v]);
      check("R4 tick on last low cycle", lastTick, 1);
      check("R4 one tick in period", tk, 1);
      window(4 * (VHI[v] + VLO[v]), 1'b1, tk, hits);
      check("R4 ticks over four periods", tk, 4);
    end

    // R5: zero high count
    restart(0, 4);
    window(50, 1'b1, tk, hits);
    check("R5 no high with zero high count", hits, 0);
    check("R5 no tick with zero high count", tk, 0);

    // R6: zero low count
    restart(3, 0);
    wait_level(1'b1);
    window(30, 1'b1, tk, hits);
    check("R6 constant high", hits, 30);
    check("R6 tick every high period", tk, 10);

    // R7: disable and restart timing
    restart(2, 3);
    wait_level(1'b1);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    window(20, 1'b1, tk, hits);
    check("R7 idle while disabled", hits, 0);
    check("R7 no tick while disabled", tk, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R7 low one edge after enable", int'(irOut), 0);
    @(negedge clk);
    check("R7 high two edges after enable", int'(irOut), 1);

    // R8: gate closed, counter keeps running
    gate = 1'b0;
    @(negedge clk);
    window(25, 1'b1, tk, hits);
    check("R8 idle level with gate closed", hits, 0);
    check("R8 ticks continue with gate closed", tk, 5);

    // R9: inversion
    invert = 1'b1;
    @(negedge clk);
    check("R9 inverted idle level after one edge", int'(irOut), 1);
    gate = 1'b1;
    @(negedge clk);
    window(25, 1'b0, tk, hits);
    check("R9 inverted carrier low cycles", hits, 10);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 inverted idle while disabled", int'(irOut), 1);
    invert = 1'b0;
    @(negedge clk);
    check("R9 polarity returns after one edge", int'(irOut), 0);

    finish_run();
  end
endmodule